// File: doc/BRIEF.md
# Synchronous Burst SRAM Write Front-End

This block is the write-side control front end of a pipelined synchronous burst SRAM. On every rising clock edge it samples an address bus, three chip enables, two address-load strobes (one for a processor, one for a memory controller), a burst step input, a global write input, a lane-write enable, per-lane select inputs, the output-drive enable and the write data. From these it decides whether a write occurs, which address it goes to and which byte lanes it touches. It registers that write request (`wr_en`, `wr_addr`, `wr_strb`, `wr_data`), and the request is applied to a small internal array on the following edge.

A burst begins when either load strobe is accepted. It then walks through four addresses by stepping the two low address bits 0,1,2,3 and wrapping around, while the upper bits keep the loaded value. The step input advances the burst, pauses it or leaves it at the current address. A controller-side load during a burst restarts the burst at a new address. The data width is a parameter: 18 bits with 2 lanes of 9 bits, or 36 bits with 4 lanes. A combinational read port exposes the array contents so that the result of each write sequence can be observed.

The pins are SRAM-style control pins and carry no back-pressure. A write is accepted on the edge where it is presented, or it is dropped under the rules below.

Top module: `sbw_front`

## Requirements
- R1: A load strobe is accepted as a load only when `en_a_n`=0, `en_b_n`=0 and `en_c`=1. A strobe taken under any other enable combination ends the current burst. Nothing is written in that cycle or in later continuation cycles until the next accepted load.
- R2: With `all_wr_n`=0, a write drives every lane strobe high, whatever `lane_wr_n` and `lane_sel_n` are.
- R3: With `all_wr_n`=1 and `lane_wr_n`=0, lane i (data bits [9i+8:9i]) is written exactly when `lane_sel_n[i]`=0, and all lanes low gives a full-width write. With `all_wr_n`=1 and `lane_wr_n`=1, no write occurs.
- R4: In a cycle where `cpu_lds_n`=0 and `en_a_n`=0, nothing is written, whatever the write inputs are.
- R5: An accepted controller-side load (`ctl_lds_n`=0, with no processor load taken) writes to the address loaded in that same cycle.
- R6: In a continuation cycle of an active burst with `step_n`=1, the address holds and any write goes to the current address (suspend).
- R7: In a continuation cycle with `step_n`=0, bits [1:0] of the address step by +1 modulo 4 and the write goes to the new address. Bits above bit 1 keep the loaded value.
- R8: A controller-side load during an active burst replaces the burst address, and the following beats continue from the new address.
- R9: With `drv_en_n`=0 in a cycle, no write occurs in that cycle.
- R10: When both strobes are low in the same cycle, the processor strobe wins. The processor strobe is ignored while `en_a_n`=1.
- R11: A write sampled at edge k appears on `wr_en`/`wr_addr`/`wr_strb`/`wr_data` after edge k, reaches the array at edge k+1, and `rd_data` follows `rd_addr` combinationally.
- R12: After reset, `wr_en`=0 and no burst is active, so continuation cycles write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | External address, sampled on load |
| en_a_n | input | 1 | Primary chip enable, active low (also gates the processor strobe) |
| en_b_n | input | 1 | Second chip enable, active low |
| en_c | input | 1 | Third chip enable, active high |
| cpu_lds_n | input | 1 | Processor-side address load strobe, active low |
| ctl_lds_n | input | 1 | Controller-side address load strobe, active low |
| step_n | input | 1 | Burst step, low advances and high holds |
| all_wr_n | input | 1 | Global full-width write, active low |
| lane_wr_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| drv_en_n | input | 1 | Output drive enable, must be high for a write |
| wdata | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word at `rd_addr` |
| wr_en | output | 1 | Registered write request |
| wr_addr | output | ADDR_W | Registered write address |
| wr_strb | output | LANES | Registered lane strobes |
| wr_data | output | DATA_W | Registered write data |

## Verification
The assertions assume that every control pin holds a defined 0 or 1 from the first edge after reset. They also assume that a burst address only changes through a load or a step, so any change in address history comes from the strobes and `step_n`. The stimulus keeps to this by returning every pin to a defined idle value between sequences (strobes, step and write inputs high, drive enable high, chip enables selecting) and by changing pins only at the falling edge. Array reads target only words that the same sequence wrote first, so no check depends on the unreset contents of the array.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int unsigned LANE_W  = 9;
  localparam int unsigned BURST_W = 2;

  function automatic int unsigned lanes_for(input int unsigned dw);
    return dw / LANE_W;
  endfunction
endpackage

// File: rtl/sbw_decode.sv
module sbw_decode #(
  parameter int unsigned LANES = 2
) (
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic             en_c,
  input  logic             cpu_lds_n,
  input  logic             ctl_lds_n,
  input  logic             step_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             drv_en_n,
  input  logic             active,
  output logic             load,
  output logic             kill,
  output logic             cont,
  output logic             advance,
  output logic             do_write,
  output logic [LANES-1:0] strb
);
  logic selected;
  logic cpu_take;
  logic ctl_take;
  logic any_take;
  logic lanes_hit;
  logic write_slot;

  always_comb begin
    selected = !en_a_n && !en_b_n && en_c;
    // processor strobe is qualified by the primary enable and wins ties
    cpu_take = !cpu_lds_n && !en_a_n;
    ctl_take = !cpu_take && !ctl_lds_n;
    any_take = cpu_take || ctl_take;

    load    = any_take && selected;
    kill    = any_take && !selected;
    cont    = !any_take && active;
    advance = cont && !step_n;

    if (!all_wr_n)       strb = '1;
    else if (!lane_wr_n) strb = ~lane_sel_n;
    else                 strb = '0;
    lanes_hit = |strb;

    // a processor load never writes; controller load and continuation may
    write_slot = (ctl_take && selected) || cont;
    do_write   = write_slot && drv_en_n && lanes_hit;
  end
endmodule

// File: rtl/sbw_burst.sv
module sbw_burst #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              kill,
  input  logic              cont,
  input  logic              advance,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              active,
  output logic [ADDR_W-1:0] eff_addr
);
  import sbw_pkg::*;

  logic [ADDR_W-1:0]  addr_q;
  logic [BURST_W-1:0] next_lo;

  always_comb begin
    next_lo = addr_q[BURST_W-1:0] + BURST_W'(1);
    if (load)         eff_addr = load_addr;
    else if (advance) eff_addr = {addr_q[ADDR_W-1:BURST_W], next_lo};
    else              eff_addr = addr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      addr_q <= '0;
    end else begin
      if (load)      active <= 1'b1;
      else if (kill) active <= 1'b0;
      if (load || advance) addr_q <= eff_addr;
    end
  end

  // R6: a held continuation keeps the burst address
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !advance) |=> (addr_q == $past(addr_q)));

  // R7: a step moves only the low two bits, by one, with wrap
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> ((addr_q[BURST_W-1:0] == $past(addr_q[BURST_W-1:0]) + BURST_W'(1))
                 && (addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W]))));

  // R1: a strobe with a deselecting enable ends the burst
  p_kill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !active);

  // R8: a load replaces the address
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active && addr_q == $past(load_addr)));
endmodule

// File: rtl/sbw_array.sv
module sbw_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_strb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import sbw_pkg::*;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_strb[g])
        bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/sbw_front.sv
module sbw_front #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned LANES  = sbw_pkg::lanes_for(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_a_n,
  input  logic              en_b_n,
  input  logic              en_c,
  input  logic              cpu_lds_n,
  input  logic              ctl_lds_n,
  input  logic              step_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              drv_en_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_strb,
  output logic [DATA_W-1:0] wr_data
);
  logic              load, kill, cont, advance, do_write, active;
  logic [LANES-1:0]  strb;
  logic [ADDR_W-1:0] eff_addr;

  sbw_decode #(.LANES(LANES)) u_decode (
    .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c),
    .cpu_lds_n(cpu_lds_n), .ctl_lds_n(ctl_lds_n), .step_n(step_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .drv_en_n(drv_en_n), .active(active),
    .load(load), .kill(kill), .cont(cont), .advance(advance),
    .do_write(do_write), .strb(strb)
  );

  sbw_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load), .kill(kill), .cont(cont),
    .advance(advance), .load_addr(addr), .active(active), .eff_addr(eff_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_strb <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= do_write;
      wr_addr <= eff_addr;
      wr_strb <= do_write ? strb : '0;
      wr_data <= wdata;
    end
  end

  sbw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R4: a processor load cycle never writes
  p_cpu_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_lds_n && !en_a_n) |=> !wr_en);

  // R9: output drive enabled blocks the write
  p_drive_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en_n |=> !wr_en);

  // R2: global write fills every lane
  p_global_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(!all_wr_n)) |-> (wr_strb == '1));

  // R3: a write always carries at least one lane
  p_lane_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_strb != '0));

  // R1: a deselected strobe produces no write
  p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ctl_lds_n || (!cpu_lds_n && !en_a_n)) && !(!en_a_n && !en_b_n && en_c)) |=> !wr_en);
endmodule

// File: tb/tb_sbw_front.sv
`timescale 1ns/1ps
module tb_sbw_front;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 18;
  localparam int unsigned NL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          en_a_n = 1'b0, en_b_n = 1'b0, en_c = 1'b1;
  logic          cpu_lds_n = 1'b1, ctl_lds_n = 1'b1, step_n = 1'b1;
  logic          all_wr_n = 1'b1, lane_wr_n = 1'b1, drv_en_n = 1'b1;
  logic [NL-1:0] lane_sel_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [NL-1:0] wr_strb;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sbw_front #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .en_c(en_c), .cpu_lds_n(cpu_lds_n), .ctl_lds_n(ctl_lds_n), .step_n(step_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .drv_en_n(drv_en_n), .wdata(wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_data(wr_data)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: pins set at the falling edge, returns 1 ns after the rising edge
  task automatic beat(input logic cpu, input logic ctl, input logic stp,
                      input logic gw, input logic lw, input logic [NL-1:0] sel,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_lds_n = cpu; ctl_lds_n = ctl; step_n = stp;
    all_wr_n = gw; lane_wr_n = lw; lane_sel_n = sel; addr = a; wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    beat(1, 1, 1, 1, 1, '1, '0, '0);
    en_a_n = 1'b0; en_b_n = 1'b0; en_c = 1'b1; drv_en_n = 1'b1;
  endtask

  task automatic peek(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    rd_addr = a;
    #1;
    chk(req, {18'b0, rd_data}, {18'b0, exp});
  endtask

  task automatic t_reset();
    chk("R12 wr_en after reset", {35'b0, wr_en}, 36'd0);
    beat(1, 1, 1, 0, 1, '1, 8'h05, 18'h11111);   // continuation with no burst
    chk("R12 no burst after reset", {35'b0, wr_en}, 36'd0);
  endtask

  task automatic t_ctl_single();
    beat(1, 0, 1, 0, 1, '1, 8'h10, 18'h2A5A5);
    chk("R5 wr_en on ctl load", {35'b0, wr_en}, 36'd1);
    chk("R11 wr_addr", {28'b0, wr_addr}, 36'h10);
    chk("R2 full strobe", {34'b0, wr_strb}, 36'h3);
    peek("R11 array not yet written", 8'h10, rd_data); // placeholder read to set addr
    idle();
    peek("R5 array word", 8'h10, 18'h2A5A5);
  endtask

  task automatic t_cpu_burst();
    beat(0, 1, 1, 0, 1, '1, 8'h21, 18'h3FFFF);
    chk("R4 no write on cpu load", {35'b0, wr_en}, 36'd0);
    beat(1, 1, 1, 0, 1, '1, 8'h00, 18'h00A01);
    beat(1, 1, 0, 0, 1, '1, 8'h00, 18'h00A02);
    beat(1, 1, 0, 0, 1, '1, 8'h00, 18'h00A03);
    beat(1, 1, 0, 0, 1, '1, 8'hFF, 18'h00A04);
    chk("R7 wrap address", {28'b0, wr_addr}, 36'h20);
    idle();
    peek("R7 beat0", 8'h21, 18'h00A01);
    peek("R7 beat1", 8'h22, 18'h00A02);
    peek("R7 beat2", 8'h23, 18'h00A03);
    peek("R7 beat3 wrap", 8'h20, 18'h00A04);
  endtask

  task automatic t_suspend();
    beat(1, 0, 1, 0, 1, '1, 8'h40, 18'h0B000);
    beat(1, 1, 0, 0, 1, '1, 8'h00, 18'h0B001);
    beat(1, 1, 1, 0, 1, '1, 8'h00, 18'h0B002);
    chk("R6 held address", {28'b0, wr_addr}, 36'h41);
    beat(1, 1, 1, 1, 1, '1, 8'h00, 18'h0B0FF);
    chk("R3 no write without enables", {35'b0, wr_en}, 36'd0);
    beat(1, 1, 0, 0, 1, '1, 8'h00, 18'h0B003);
    idle();
    peek("R6 suspended overwrite", 8'h41, 18'h0B002);
    peek("R6 resume after suspend", 8'h42, 18'h0B003);
    peek("R5 first beat", 8'h40, 18'h0B000);
  endtask

  task automatic t_restart();
    beat(0, 1, 1, 0, 1, '1, 8'h50, 18'h00000);
    beat(1, 1, 1, 0, 1, '1, 8'h00, 18'h0C000);
    beat(1, 1, 0, 0, 1, '1, 8'h00, 18'h0C001);
    beat(1, 0, 0, 0, 1, '1, 8'h60, 18'h0C002);
    beat(1, 1, 0, 0, 1, '1, 8'h00, 18'h0C003);
    idle();
    peek("R8 before restart", 8'h51, 18'h0C001);
    peek("R8 restart word", 8'h60, 18'h0C002);
    peek("R8 continues from new", 8'h61, 18'h0C003);
  endtask

  task automatic t_lanes();
    beat(1, 0, 1, 0, 1, '1, 8'h70, 18'h1E0F0);
    beat(1, 0, 1, 1, 0, 2'b10, 8'h70, 18'h00155);
    chk("R3 lane0 strobe", {34'b0, wr_strb}, 36'h1);
    beat(1, 0, 1, 1, 0, 2'b01, 8'h71, 18'h2AA00);
    idle();
    peek("R3 lane0 only", 8'h70, {9'h0F0, 9'h155});
    beat(1, 0, 1, 1, 1, 2'b00, 8'h70, 18'h3FFFF);
    chk("R3 lane enable high no write", {35'b0, wr_en}, 36'd0);
    beat(1, 0, 1, 1, 0, 2'b00, 8'h72, 18'h12345);
    chk("R3 all lanes strobe", {34'b0, wr_strb}, 36'h3);
    beat(1, 0, 1, 0, 0, 2'b11, 8'h73, 18'h06789);
    chk("R2 global overrides lane selects", {34'b0, wr_strb}, 36'h3);
    idle();
    peek("R3 unchanged after ignored", 8'h70, {9'h0F0, 9'h155});
    peek("R3 full via lanes", 8'h72, 18'h12345);
    peek("R2 full via global", 8'h73, 18'h06789);
  endtask

  task automatic t_drive();
    beat(1, 0, 1, 0, 1, '1, 8'h80, 18'h0D00D);
    drv_en_n = 1'b0;
    beat(1, 0, 1, 0, 1, '1, 8'h80, 18'h0EEEE);
    chk("R9 drive enabled blocks write", {35'b0, wr_en}, 36'd0);
    idle();
    peek("R9 word kept", 8'h80, 18'h0D00D);
  endtask

  task automatic t_select();
    beat(1, 0, 1, 0, 1, '1, 8'h90, 18'h01234);
    @(negedge clk); en_c = 1'b0;
    beat(1, 0, 1, 0, 1, '1, 8'h90, 18'h0FFF0);
    chk("R1 deselected load no write", {35'b0, wr_en}, 36'd0);
    en_c = 1'b1;
    beat(1, 1, 1, 0, 1, '1, 8'h00, 18'h0FFF1);
    chk("R1 burst ended", {35'b0, wr_en}, 36'd0);
    en_b_n = 1'b1;
    beat(1, 0, 1, 0, 1, '1, 8'h91, 18'h0FFF2);
    chk("R1 second enable deselects", {35'b0, wr_en}, 36'd0);
    idle();
    peek("R1 word kept", 8'h90, 18'h01234);
  endtask

  task automatic t_priority();
    beat(0, 0, 1, 0, 1, '1, 8'hA0, 18'h0AAAA);
    chk("R10 cpu wins, no write", {35'b0, wr_en}, 36'd0);
    beat(1, 1, 1, 0, 1, '1, 8'h00, 18'h0A001);
    chk("R10 write to cpu address", {28'b0, wr_addr}, 36'hA0);
    en_a_n = 1'b1;
    beat(0, 1, 1, 0, 1, '1, 8'h33, 18'h0A002);
    chk("R10 cpu strobe ignored, continuation writes", {35'b0, wr_en}, 36'd1);
    en_a_n = 1'b0;
    idle();
    peek("R10 continuation word", 8'hA0, 18'h0A002);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ctl_single();
    t_cpu_burst();
    t_suspend();
    t_restart();
    t_lanes();
    t_drive();
    t_select();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule